// File: doc/BRIEF.md
# Predicate Register File with Compare Unit

This block keeps a set of 64 single-bit predicate flags and runs compare operations that write them. A compare takes two 64-bit operands, a relational test, a compare type, a guard flag index and two destination flag indices. In one clock cycle it evaluates the test, reads the guard flag and updates both destinations. The destinations get either the result and its inverse, or an AND/OR accumulation of the result.

Any number of read lanes (a parameter) turn a 6-bit flag index into its current value in the same cycle. An issue stage uses them to decide whether an instruction's qualifying flag enables it. Flag 0 is hard-wired true. A write reaches the flags at the clock edge where the compare is issued, and it is visible on the read lanes right after that edge.

Top module: `pred_cmp_unit`

## Requirements
- R1: After reset every flag from 1 to 63 reads 0, and flag 0 reads 1 on every read lane at all times.
- R2: Test codes are 0 eq, 1 ne, 2 signed lt, 3 signed le, 4 signed gt, 5 signed ge, 6 unsigned lt, 7 unsigned le, 8 unsigned gt, 9 unsigned ge; operands are 64-bit two's complement for the signed tests.
- R3: Type 0 (normal): with a true guard, the first destination gets the test result and the second gets its inverse; with a false guard neither destination changes.
- R4: Type 1 (unconditional): with a true guard it behaves as type 0; with a false guard both destinations are written 0.
- R5: Type 2 (and): with a true guard and a false result both destinations are cleared; otherwise both are unchanged. Type 4 (and-complement) does the same with the result inverted.
- R6: Type 3 (or): with a true guard and a true result both destinations are set; otherwise both are unchanged. Type 5 (or-complement) does the same with the result inverted.
- R7: A write aimed at flag 0 is dropped, and flag 0 still reads 1 afterwards. The other destination of the same compare is still written.
- R8: A compare whose two destination indices are equal, whose test code is above 9 or whose type code is above 5 raises `cmpIllegal` in the issue cycle and writes nothing.
- R9: A write from a compare issued in cycle N is visible on all read lanes after the clock edge that ends cycle N. With `cmpValid` low, no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Issue a compare this cycle |
| cmpTest | input | 4 | Relational test code |
| cmpType | input | 3 | Compare type code |
| cmpGuard | input | 6 | Guard flag index |
| cmpDst1 | input | 6 | First destination index |
| cmpDst2 | input | 6 | Second destination index |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| cmpIllegal | output | 1 | Issued compare is illegal and was dropped |
| rdIdx | input | 6*NUM_RD | Packed read-lane indices, lane 0 in the low bits |
| rdVal | output | NUM_RD | Read-lane flag values |

## Verification
The bench builds the unit with three read lanes and the default 64-bit operand width. The wider read port lets it check several flags in one step, and it confirms that every lane decodes flag 0 and the other flags the same way. The full operand width is what makes the signed and unsigned tests disagree. An all-ones operand against a small positive value, and the most negative value against the most positive value, are cases where the signed and unsigned orders differ. A long random run with random guards and random destinations drives all six types through true and false guards and through writes to flag 0. After that run, every flag is compared against the model.

// File: rtl/pred_cmp_pkg.sv
package pred_cmp_pkg;

  localparam int PRED_CNT = 64;
  localparam int IDX_W    = $clog2(PRED_CNT);

  typedef enum logic [3:0] {
    TST_EQ  = 4'd0, TST_NE  = 4'd1,
    TST_LT  = 4'd2, TST_LE  = 4'd3, TST_GT  = 4'd4, TST_GE  = 4'd5,
    TST_LTU = 4'd6, TST_LEU = 4'd7, TST_GTU = 4'd8, TST_GEU = 4'd9
  } testSel_e;

  typedef enum logic [2:0] {
    CT_NORM  = 3'd0, CT_UNC  = 3'd1, CT_AND  = 3'd2,
    CT_OR    = 3'd3, CT_ANDC = 3'd4, CT_ORC  = 3'd5
  } cmpType_e;

  typedef struct packed {
    logic             wrEn1;
    logic             wrVal1;
    logic [IDX_W-1:0] wrIdx1;
    logic             wrEn2;
    logic             wrVal2;
    logic [IDX_W-1:0] wrIdx2;
  } predWr_t;

endpackage

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        testCode,
  output logic              result,
  output logic              testBad
);
  import pred_cmp_pkg::*;

  logic isEq, sLess, uLess;

  assign isEq  = (opA == opB);
  assign sLess = ($signed(opA) < $signed(opB));
  assign uLess = (opA < opB);

  always_comb begin
    testBad = 1'b0;
    case (testCode)
      TST_EQ:  result = isEq;
      TST_NE:  result = !isEq;
      TST_LT:  result = sLess;
      TST_LE:  result = sLess || isEq;
      TST_GT:  result = !(sLess || isEq);
      TST_GE:  result = !sLess;
      TST_LTU: result = uLess;
      TST_LEU: result = uLess || isEq;
      TST_GTU: result = !(uLess || isEq);
      TST_GEU: result = !uLess;
      default: begin
        result  = 1'b0;
        testBad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/pred_cmp_ctrl.sv
module pred_cmp_ctrl
  import pred_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpValid,
  input  logic [2:0]       cmpType,
  input  logic [IDX_W-1:0] cmpDst1,
  input  logic [IDX_W-1:0] cmpDst2,
  input  logic             guardVal,
  input  logic             result,
  input  logic             testBad,
  output logic             cmpIllegal,
  output predWr_t          wrStb
);

  logic typeBad, sameDst, doIt;
  logic enBoth, valBoth, splitVals;

  assign typeBad    = (cmpType > 3'd5);
  assign sameDst    = (cmpDst1 == cmpDst2);
  assign cmpIllegal = cmpValid && (typeBad || sameDst || testBad);
  assign doIt       = cmpValid && !cmpIllegal;

  always_comb begin
    enBoth    = 1'b0;
    valBoth   = 1'b0;
    splitVals = 1'b0;
    case (cmpType)
      CT_NORM: begin enBoth = guardVal;             splitVals = 1'b1; end
      CT_UNC:  begin enBoth = 1'b1;                 splitVals = 1'b1; end
      CT_AND:  begin enBoth = guardVal && !result;  valBoth = 1'b0;   end
      CT_OR:   begin enBoth = guardVal &&  result;  valBoth = 1'b1;   end
      CT_ANDC: begin enBoth = guardVal &&  result;  valBoth = 1'b0;   end
      CT_ORC:  begin enBoth = guardVal && !result;  valBoth = 1'b1;   end
      default: begin enBoth = 1'b0; end
    endcase
  end

  always_comb begin
    wrStb.wrEn1  = doIt && enBoth;
    wrStb.wrEn2  = doIt && enBoth;
    wrStb.wrIdx1 = cmpDst1;
    wrStb.wrIdx2 = cmpDst2;
    if (splitVals) begin
      wrStb.wrVal1 = guardVal &&  result;
      wrStb.wrVal2 = guardVal && !result;
    end else begin
      wrStb.wrVal1 = valBoth;
      wrStb.wrVal2 = valBoth;
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cmpIllegal |-> !(wrStb.wrEn1 || wrStb.wrEn2)); // R8

  AST_UNC_ALWAYS_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && !cmpIllegal && cmpType == CT_UNC) |-> (wrStb.wrEn1 && wrStb.wrEn2)); // R4

  AST_NORM_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrEn1 && cmpType == CT_NORM) |-> (wrStb.wrVal1 != wrStb.wrVal2)); // R3

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |-> !(wrStb.wrEn1 || wrStb.wrEn2)); // R9

endmodule

// File: rtl/pred_cmp_regs.sv
module pred_cmp_regs
  import pred_cmp_pkg::*;
#(
  parameter int NUM_RD = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  predWr_t                 wrStb,
  input  logic [IDX_W-1:0]        guardIdx,
  output logic                    guardVal,
  input  logic [NUM_RD*IDX_W-1:0] rdIdx,
  output logic [NUM_RD-1:0]       rdVal
);

  logic [PRED_CNT-1:0] preds;
  logic keep1, keep2;

  assign keep1 = wrStb.wrEn1 && (wrStb.wrIdx1 != '0);
  assign keep2 = wrStb.wrEn2 && (wrStb.wrIdx2 != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preds <= '0;
    end else begin
      if (keep1) preds[wrStb.wrIdx1] <= wrStb.wrVal1;
      if (keep2) preds[wrStb.wrIdx2] <= wrStb.wrVal2;
    end
  end

  assign guardVal = (guardIdx == '0) ? 1'b1 : preds[guardIdx];

  for (genvar lane = 0; lane < NUM_RD; lane++) begin : g_rd
    logic [IDX_W-1:0] laneIdx;
    assign laneIdx     = rdIdx[lane*IDX_W +: IDX_W];
    assign rdVal[lane] = (laneIdx == '0) ? 1'b1 : preds[laneIdx];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    keep1 |=> preds[$past(wrStb.wrIdx1)] == $past(wrStb.wrVal1)); // R9

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb.wrEn1 || wrStb.wrEn2) |=> $stable(preds)); // R9

  AST_P0_READS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx[IDX_W-1:0] == '0) |-> rdVal[0]); // R1

endmodule

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
  import pred_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_RD = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmpValid,
  input  logic [3:0]              cmpTest,
  input  logic [2:0]              cmpType,
  input  logic [IDX_W-1:0]        cmpGuard,
  input  logic [IDX_W-1:0]        cmpDst1,
  input  logic [IDX_W-1:0]        cmpDst2,
  input  logic [DATA_W-1:0]       opA,
  input  logic [DATA_W-1:0]       opB,
  output logic                    cmpIllegal,
  input  logic [NUM_RD*IDX_W-1:0] rdIdx,
  output logic [NUM_RD-1:0]       rdVal
);

  logic    result, testBad, guardVal;
  predWr_t wrStb;

  pred_cmp_eval #(.DATA_W(DATA_W)) u_eval (
    .opA(opA), .opB(opB), .testCode(cmpTest),
    .result(result), .testBad(testBad)
  );

  pred_cmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .cmpType(cmpType),
    .cmpDst1(cmpDst1), .cmpDst2(cmpDst2), .guardVal(guardVal),
    .result(result), .testBad(testBad),
    .cmpIllegal(cmpIllegal), .wrStb(wrStb)
  );

  pred_cmp_regs #(.NUM_RD(NUM_RD)) u_regs (
    .clk(clk), .rstN(rstN), .wrStb(wrStb),
    .guardIdx(cmpGuard), .guardVal(guardVal),
    .rdIdx(rdIdx), .rdVal(rdVal)
  );

endmodule

// File: tb/pred_cmp_unit_tb.sv
module pred_cmp_unit_tb;
  localparam int NRD = 3;

  typedef struct {
    int    idx;
    bit    exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpValid = 1'b0;
  logic [3:0] cmpTest = '0;
  logic [2:0] cmpType = '0;
  logic [5:0] cmpGuard = '0, cmpDst1 = '0, cmpDst2 = '0;
  logic [63:0] opA = '0, opB = '0;
  logic cmpIllegal;
  logic [NRD*6-1:0] rdIdx = '0;
  logic [NRD-1:0] rdVal;

  int errors = 0;
  int checks = 0;
  bit model [64];
  item_t q[$];
  bit done = 0;

  always #10 clk = ~clk;

  pred_cmp_unit #(.DATA_W(64), .NUM_RD(NRD)) u_dut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .cmpTest(cmpTest),
    .cmpType(cmpType), .cmpGuard(cmpGuard), .cmpDst1(cmpDst1),
    .cmpDst2(cmpDst2), .opA(opA), .opB(opB), .cmpIllegal(cmpIllegal),
    .rdIdx(rdIdx), .rdVal(rdVal)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic bit relTest(input int t, input logic [63:0] a, input logic [63:0] b);
    case (t)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <  $signed(b);
      3: return $signed(a) <= $signed(b);
      4: return $signed(a) >  $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a <  b;
      7: return a <= b;
      8: return a >  b;
      9: return a >= b;
      default: return 0;
    endcase
  endfunction

  function automatic void mWrite(input int idx, input bit v);
    if (idx != 0) model[idx] = v;
  endfunction

  // Driver: issue one compare, check the illegal flag, update model, queue expectations
  task automatic doCmp(input int t, input int ty, input int g, input int d1, input int d2,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    bit ill, r, gv;
    @(negedge clk);
    cmpTest = t[3:0]; cmpType = ty[2:0]; cmpGuard = g[5:0];
    cmpDst1 = d1[5:0]; cmpDst2 = d2[5:0]; opA = a; opB = b; cmpValid = 1'b1;
    ill = (d1 == d2) || (t > 9) || (ty > 5);
    #1 check(cmpIllegal, ill, {tag, " illegal flag (R8)"});
    r  = relTest(t, a, b);
    gv = (g == 0) ? 1'b1 : model[g];
    if (!ill) begin
      case (ty)
        0: if (gv) begin mWrite(d1, r); mWrite(d2, !r); end
        1: begin mWrite(d1, gv && r); mWrite(d2, gv && !r); end
        2: if (gv && !r) begin mWrite(d1, 0); mWrite(d2, 0); end
        3: if (gv && r)  begin mWrite(d1, 1); mWrite(d2, 1); end
        4: if (gv && r)  begin mWrite(d1, 0); mWrite(d2, 0); end
        5: if (gv && !r) begin mWrite(d1, 1); mWrite(d2, 1); end
        default: ;
      endcase
    end
    q.push_back('{d1, model[d1], tag});
    q.push_back('{d2, model[d2], tag});
    @(negedge clk);
    cmpValid = 1'b0;
    wait (q.size() == 0);
  endtask

  task automatic queueAll(input string tag);
    for (int i = 0; i < 64; i++) q.push_back('{i, model[i], tag});
    wait (q.size() == 0);
  endtask

  // Monitor: after each rising edge, pop expectations and compare through the read lanes
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        for (int l = 0; l < NRD; l++) rdIdx[l*6 +: 6] = it.idx[5:0];
        #1;
        for (int l = 0; l < NRD; l++)
          check(rdVal[l], it.exp, $sformatf("%s p%0d lane%0d", it.tag, it.idx, l));
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    queueAll("R1 reset");

    // R2/R3 tests under a true guard (p0)
    doCmp(0, 0, 0, 1, 2, 64'd5, 64'd5, "R2 R3 eq");
    doCmp(2, 0, 0, 3, 4, '1, 64'd1, "R2 signed lt");
    doCmp(6, 0, 0, 5, 6, '1, 64'd1, "R2 unsigned lt");
    doCmp(4, 0, 0, 7, 8, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R2 signed gt");
    doCmp(8, 0, 0, 9, 10, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R2 unsigned gt");
    doCmp(3, 0, 0, 11, 12, 64'd9, 64'd9, "R2 le equal");
    doCmp(9, 0, 0, 13, 14, 64'd3, 64'd4, "R2 geu");
    // R3 false guard (p2 is 0): no change to p1/p3
    doCmp(1, 0, 2, 1, 3, 64'd1, 64'd2, "R3 false guard");
    // R4 unconditional with false guard writes zeros
    doCmp(0, 1, 2, 1, 4, 64'd1, 64'd1, "R4 unc false guard");
    doCmp(0, 1, 0, 20, 21, 64'd1, 64'd1, "R4 unc true guard");
    // R5 and-types
    doCmp(0, 1, 0, 22, 23, 64'd1, 64'd2, "R5 prep");
    doCmp(0, 0, 0, 24, 25, 64'd7, 64'd7, "R5 prep2");
    doCmp(0, 2, 0, 24, 20, 64'd1, 64'd2, "R5 and false result");
    doCmp(0, 2, 0, 13, 1, 64'd1, 64'd1, "R5 and true result");
    doCmp(0, 4, 0, 13, 9, 64'd1, 64'd1, "R5 andcm");
    // R6 or-types
    doCmp(0, 3, 0, 26, 27, 64'd3, 64'd3, "R6 or true");
    doCmp(0, 3, 0, 28, 29, 64'd3, 64'd4, "R6 or false");
    doCmp(0, 5, 0, 30, 31, 64'd3, 64'd4, "R6 orcm");
    doCmp(0, 3, 2, 32, 33, 64'd3, 64'd3, "R6 or false guard");
    // R7 write to p0 dropped, other dest written
    doCmp(0, 0, 0, 0, 34, 64'd1, 64'd2, "R7 p0 dst1");
    doCmp(0, 1, 0, 35, 0, 64'd1, 64'd1, "R7 p0 dst2");
    // R8 illegal cases
    doCmp(0, 1, 0, 40, 40, 64'd1, 64'd1, "R8 same dst");
    doCmp(12, 1, 0, 41, 42, 64'd1, 64'd1, "R8 bad test");
    doCmp(0, 7, 0, 43, 44, 64'd1, 64'd1, "R8 bad type");
    queueAll("R9 after directed");

    // R9 random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) b[63] = ~b[63];
      doCmp($urandom_range(0, 10), $urandom_range(0, 6), $urandom_range(0, 63),
            $urandom_range(0, 63), $urandom_range(0, 63), a, b, "R9 random");
    end
    queueAll("R9 final sweep");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule